// File: doc/BRIEF.md
# Loopback UART Register Block

This block presents the register set of a 16550-style serial port to a host, but has no serial line behind it. Every byte the host writes to the transmit data offset is placed straight into a small receive queue, and the host reads it back from the same offset. The queue, its fill threshold, the overrun flag and four interrupt sources behave the way driver software for such a port expects. This makes the block a loopback target for exercising that software.

The host side is a byte-wide register bus with a 3-bit offset, a write strobe, a read strobe, write data and combinational read data. Both strobes act on the offset at the rising clock edge, and both may be high in the same cycle. A single level-sensitive interrupt output stays high until the host reads the interrupt identification register. The reset input is asynchronous and active low. Inside the block its release is synchronised over two clock cycles.

Top module: `lbuart_regs`

## Requirements
- R1: After reset, offset 5 reads 0x60, offset 2 reads 0x01, offsets 1, 3, 4 and 7 read 0x00, and irq is low.
- R2: Writing offset 3 stores the byte, and it reads back there. Bit 7 of that byte is the divisor access flag. Writing it as 1 also zeroes the 16-bit divisor. While the flag is set, offsets 0 and 1 write and read the divisor's low and high bytes. No queue push or pop happens, and the interrupt enable register is not touched.
- R3: With the divisor access flag clear, a write to offset 0 pushes the byte into the queue. A read of offset 0 returns the oldest byte and removes it, or returns 0x00 when the queue is empty. Offset 5 bit 0 is 1 whenever the queue holds at least one byte.
- R4: The queue holds 16 bytes when offset 2 was last written with bit 0 set. Otherwise it holds 1 byte.
- R5: A push into a full queue drops the byte and sets offset 5 bit 1. A successful push clears that bit, and so does a read of offset 5.
- R6: A dropped push raises irq when interrupt enable bit 2 is set.
- R7: Offset 2 write bits 7:6 set the fill threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. When queue bit 0 is clear, the threshold is 1. A successful push raises irq when interrupt enable bit 0 is set and the occupancy after the cycle equals the threshold exactly.
- R8: Writing offset 2 with bit 1 or bit 2 set empties the queue.
- R9: Writing the interrupt enable register (offset 1, access flag clear) with bit 1 set raises irq only if the queue is empty at that moment.
- R10: With interrupt enable bit 3 set, a write to offset 4 raises irq if bit 0, 1 or 3 of the byte is set. The stored byte reads back at offset 4.
- R11: Writes to offsets 5 and 6 have no effect. Offset 6 reads 0x00, and offset 7 stores and returns any byte.
- R12: irq stays high until offset 2 is read, and that read clears every pending source. Offset 2 reads {queue 16-deep ? 2'b11 : 2'b00, 2'b00, id[2:0], no_irq}. id is 011 for overrun, 010 for threshold, 001 for empty-on-enable and 000 for modem-control, in that order of priority.
- R13: A write and a read of offset 0 in the same cycle return the current oldest byte and push the new byte, even when the queue is full. Occupancy does not change and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (pops or clears on the edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on one clock edge: a push and a pop of the queue, when both strobes are high at offset 0. The bench provokes this with a single-entry queue that is already full. It checks that the read returns the old byte and that the status register afterwards shows one entry and no overrun. It also checks that the next read returns the new byte. A second collision, between an overrun source and a threshold source, is judged through the identification code: the overrun code must win, and a single identification read must clear both sources.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  // register offsets
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_ID    = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  // interrupt source index, higher index wins
  localparam int SRC_MODEM = 0;
  localparam int SRC_THRE  = 1;
  localparam int SRC_RXD   = 2;
  localparam int SRC_LINE  = 3;
  localparam int NSRC      = 4;

  function automatic logic [7:0] fill_threshold(input logic [1:0] sel, input logic deep);
    logic [7:0] lvl;
    case (sel)
      2'b00:   lvl = 8'd1;
      2'b01:   lvl = 8'd4;
      2'b10:   lvl = 8'd8;
      default: lvl = 8'd14;
    endcase
    return deep ? lvl : 8'd1;
  endfunction
endpackage

// File: rtl/lbu_fifo.sv
module lbu_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         clr,
  input  logic                         deep,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_nxt,
  output logic                         push_ok,
  output logic                         push_drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head, tail, head_nxt, tail_nxt;
  logic [CW-1:0] limit;
  logic          pop_ok;

  assign limit     = deep ? CW'(DEPTH) : CW'(1);
  assign pop_ok    = pop && (count != '0);
  assign push_ok   = push && ((count < limit) || pop_ok);
  assign push_drop = push && !push_ok;
  assign dout      = mem[head];

  always_comb begin
    head_nxt  = head;
    tail_nxt  = tail;
    count_nxt = count + CW'(push_ok) - CW'(pop_ok);
    if (pop_ok)  head_nxt = (head == AW'(DEPTH-1)) ? '0 : head + 1'b1;
    if (push_ok) tail_nxt = (tail == AW'(DEPTH-1)) ? '0 : tail + 1'b1;
    if (clr) begin
      head_nxt  = '0;
      tail_nxt  = '0;
      count_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_nxt;
      tail  <= tail_nxt;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[tail] <= din;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R4
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> $stable(count)); // R5
endmodule

// File: rtl/lbu_irq.sv
module lbu_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         ack,
  output logic         irq,
  output logic [2:0]   id
);
  logic [N-1:0] pend, pend_nxt;

  // a source raised in the acknowledge cycle survives it
  assign pend_nxt = (ack ? '0 : pend) | set;
  assign irq      = |pend;

  always_comb begin
    id = 3'd0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) id = 3'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq); // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack && (set == '0) |=> !irq); // R12
endmodule

// File: rtl/lbuart_regs.sv
module lbuart_regs #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  import lbu_pkg::*;
  localparam int CW = $clog2(DEPTH+1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [7:0] ier, lcr, mcr, scr, div_lo, div_hi;
  logic [7:0] ier_n, lcr_n, mcr_n, scr_n, div_lo_n, div_hi_n;
  logic       deep, deep_n, ovr, ovr_n;
  logic [1:0] tsel, tsel_n;

  logic          dlab, data_wr, data_rd, fcr_wr, id_rd, ls_rd, clr;
  logic [7:0]    dout, thr_lvl;
  logic [CW-1:0] count, count_nxt;
  logic          push_ok, push_drop;
  logic [NSRC-1:0] src_set;
  logic [2:0]    irq_id;

  assign dlab    = lcr[7];
  assign data_wr = wr_en && (addr == OFS_DATA) && !dlab;
  assign data_rd = rd_en && (addr == OFS_DATA) && !dlab;
  assign fcr_wr  = wr_en && (addr == OFS_ID);
  assign id_rd   = rd_en && (addr == OFS_ID);
  assign ls_rd   = rd_en && (addr == OFS_LSTAT);
  assign clr     = fcr_wr && (wdata[1] || wdata[2]);
  assign thr_lvl = fill_threshold(tsel, deep);

  lbu_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_ni), .push(data_wr), .pop(data_rd), .clr(clr),
    .deep(deep), .din(wdata), .dout(dout), .count(count), .count_nxt(count_nxt),
    .push_ok(push_ok), .push_drop(push_drop)
  );

  always_comb begin
    src_set            = '0;
    src_set[SRC_LINE]  = push_drop && ier[2];
    src_set[SRC_RXD]   = push_ok && ier[0] && (8'(count_nxt) == thr_lvl);
    src_set[SRC_THRE]  = wr_en && (addr == OFS_IEN) && !dlab && wdata[1] && (count == '0);
    src_set[SRC_MODEM] = wr_en && (addr == OFS_MCTL) && ier[3]
                         && (wdata[0] || wdata[1] || wdata[3]);
  end

  lbu_irq #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_ni), .set(src_set), .ack(id_rd), .irq(irq), .id(irq_id)
  );

  // next-state for the control registers
  always_comb begin
    ier_n = ier; lcr_n = lcr; mcr_n = mcr; scr_n = scr;
    div_lo_n = div_lo; div_hi_n = div_hi;
    deep_n = deep; tsel_n = tsel; ovr_n = ovr;
    if (wr_en) begin
      case (addr)
        OFS_DATA: if (dlab) div_lo_n = wdata;
        OFS_IEN:  if (dlab) div_hi_n = wdata; else ier_n = wdata;
        OFS_ID: begin
          deep_n = wdata[0];
          tsel_n = wdata[7:6];
        end
        OFS_LCTL: begin
          lcr_n = wdata;
          if (wdata[7]) begin
            div_lo_n = '0;
            div_hi_n = '0;
          end
        end
        OFS_MCTL: mcr_n = wdata;
        OFS_SCR:  scr_n = wdata;
        default: ;
      endcase
    end
    if (push_drop)    ovr_n = 1'b1;
    else if (push_ok) ovr_n = 1'b0;
    else if (ls_rd)   ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ier <= '0; lcr <= '0; mcr <= '0; scr <= '0;
      div_lo <= '0; div_hi <= '0;
      deep <= 1'b0; tsel <= 2'b00; ovr <= 1'b0;
    end else begin
      ier <= ier_n; lcr <= lcr_n; mcr <= mcr_n; scr <= scr_n;
      div_lo <= div_lo_n; div_hi <= div_hi_n;
      deep <= deep_n; tsel <= tsel_n; ovr <= ovr_n;
    end
  end

  always_comb begin
    case (addr)
      OFS_DATA:  rdata = dlab ? div_lo : ((count != '0) ? dout : 8'h00);
      OFS_IEN:   rdata = dlab ? div_hi : ier;
      OFS_ID:    rdata = {deep ? 2'b11 : 2'b00, 2'b00, irq_id, ~irq};
      OFS_LCTL:  rdata = lcr;
      OFS_MCTL:  rdata = mcr;
      OFS_LSTAT: rdata = {1'b0, 2'b11, 3'b000, ovr, count != '0};
      OFS_MSTAT: rdata = 8'h00;
      default:   rdata = scr;
    endcase
  end

  AST_DLAB_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en && !rd_en && (addr == OFS_DATA) && dlab |=> $stable(count)); // R2
  AST_OVERRUN_IRQ: assert property (@(posedge clk) disable iff (!rst_ni)
    push_drop && ier[2] |=> irq); // R6
endmodule

// File: tb/lbuart_regs_tb.sv
module lbuart_regs_tb;
  logic       clk, rst_n, wr_en, rd_en, irq;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, q;
  int n_chk = 0;
  int n_fail = 0;

  lbuart_regs u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req[3:0], wr, rd, addr[2:0], wdata[7:0], expect[7:0], check}
  localparam int NV = 41;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1,  1'b0,1'b1,3'd5,8'h00,8'h60,1'b1},  // R1 status idle
    {4'd1,  1'b0,1'b1,3'd2,8'h00,8'h01,1'b1},  // R1 id idle
    {4'd1,  1'b0,1'b1,3'd1,8'h00,8'h00,1'b1},  // R1 enables zero
    {4'd2,  1'b1,1'b0,3'd3,8'h83,8'h00,1'b0},  // R2 access flag on
    {4'd2,  1'b1,1'b0,3'd0,8'h34,8'h00,1'b0},
    {4'd2,  1'b1,1'b0,3'd1,8'h12,8'h00,1'b0},
    {4'd2,  1'b0,1'b1,3'd0,8'h00,8'h34,1'b1},  // R2 divisor low
    {4'd2,  1'b0,1'b1,3'd1,8'h00,8'h12,1'b1},  // R2 divisor high
    {4'd2,  1'b0,1'b1,3'd3,8'h00,8'h83,1'b1},  // R2 line ctl readback
    {4'd2,  1'b1,1'b0,3'd3,8'h03,8'h00,1'b0},
    {4'd2,  1'b0,1'b1,3'd5,8'h00,8'h60,1'b1},  // R2 no push happened
    {4'd2,  1'b0,1'b1,3'd1,8'h00,8'h00,1'b1},  // R2 enables untouched
    {4'd2,  1'b1,1'b0,3'd3,8'h80,8'h00,1'b0},
    {4'd2,  1'b0,1'b1,3'd0,8'h00,8'h00,1'b1},  // R2 divisor zeroed
    {4'd2,  1'b0,1'b1,3'd1,8'h00,8'h00,1'b1},
    {4'd2,  1'b1,1'b0,3'd3,8'h03,8'h00,1'b0},
    {4'd3,  1'b1,1'b0,3'd0,8'hA5,8'h00,1'b0},  // R3 push
    {4'd3,  1'b0,1'b1,3'd5,8'h00,8'h61,1'b1},  // R3 data ready
    {4'd3,  1'b0,1'b1,3'd0,8'h00,8'hA5,1'b1},  // R3 pop
    {4'd3,  1'b0,1'b1,3'd0,8'h00,8'h00,1'b1},  // R3 empty reads zero
    {4'd3,  1'b0,1'b1,3'd5,8'h00,8'h60,1'b1},
    {4'd4,  1'b1,1'b0,3'd0,8'h11,8'h00,1'b0},  // R4 single entry
    {4'd5,  1'b1,1'b0,3'd0,8'h22,8'h00,1'b0},  // R5 dropped
    {4'd5,  1'b0,1'b1,3'd5,8'h00,8'h63,1'b1},  // R5 overrun set
    {4'd5,  1'b0,1'b1,3'd5,8'h00,8'h61,1'b1},  // R5 cleared by status read
    {4'd4,  1'b0,1'b1,3'd0,8'h00,8'h11,1'b1},  // R4 first byte kept
    {4'd8,  1'b1,1'b0,3'd2,8'h01,8'h00,1'b0},
    {4'd8,  1'b1,1'b0,3'd0,8'h01,8'h00,1'b0},
    {4'd8,  1'b1,1'b0,3'd0,8'h02,8'h00,1'b0},
    {4'd8,  1'b1,1'b0,3'd2,8'h03,8'h00,1'b0},  // R8 clear via bit 1
    {4'd8,  1'b0,1'b1,3'd5,8'h00,8'h60,1'b1},
    {4'd8,  1'b1,1'b0,3'd0,8'h07,8'h00,1'b0},
    {4'd8,  1'b1,1'b0,3'd2,8'h05,8'h00,1'b0},  // R8 clear via bit 2
    {4'd8,  1'b0,1'b1,3'd5,8'h00,8'h60,1'b1},
    {4'd11, 1'b1,1'b0,3'd7,8'h5A,8'h00,1'b0},
    {4'd11, 1'b0,1'b1,3'd7,8'h00,8'h5A,1'b1},  // R11 scratch
    {4'd11, 1'b1,1'b0,3'd5,8'hFF,8'h00,1'b0},
    {4'd11, 1'b0,1'b1,3'd5,8'h00,8'h60,1'b1},  // R11 status write ignored
    {4'd11, 1'b1,1'b0,3'd6,8'hFF,8'h00,1'b0},
    {4'd11, 1'b0,1'b1,3'd6,8'h00,8'h00,1'b1},  // R11 modem status zero
    {4'd12, 1'b0,1'b1,3'd2,8'h00,8'hC1,1'b1}   // R12 deep queue, idle
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic r, input logic [2:0] a,
                     input logic [7:0] d, output logic [7:0] rq);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #5 rq = rdata;
    @(posedge clk);
    #1 wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    acc(1'b1, 1'b0, a, d, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    acc(1'b0, 1'b1, a, 8'h00, v);
    chk(tag, v, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #4 chk(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic do_reset;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 3'd0; wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    irq_chk("R1 irq after reset", 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      acc(v[21], v[20], v[19:17], v[16:9], q);
      if (v[0]) chk($sformatf("R%0d vector %0d", v[25:22], i), q, v[8:1]);
    end

    // R4 / R6 / R5: sixteen entries, then overrun with line interrupt
    wr(3'd1, 8'h04);
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i + 8'h40));
    irq_chk("R4 sixteen accepted", 1'b0);
    wr(3'd0, 8'hEE);
    irq_chk("R6 overrun irq", 1'b1);
    rd_chk("R5 overrun flag", 3'd5, 8'h63);
    rd_chk("R12 line status id", 3'd2, 8'hC6);
    irq_chk("R12 id read clears", 1'b0);
    for (int i = 0; i < 16; i++) rd_chk("R4 deep order", 3'd0, 8'(i + 8'h40));
    rd_chk("R3 empty after drain", 3'd0, 8'h00);

    // R7: threshold 14, exact match only
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hC1);
    wr(3'd1, 8'h01);
    for (int i = 0; i < 13; i++) wr(3'd0, 8'(i));
    irq_chk("R7 below threshold", 1'b0);
    wr(3'd0, 8'h0D);
    irq_chk("R7 threshold 14 reached", 1'b1);
    rd_chk("R12 rx data id", 3'd2, 8'hC4);
    wr(3'd0, 8'h0E);
    irq_chk("R7 past threshold silent", 1'b0);
    wr(3'd2, 8'h43);
    for (int i = 0; i < 3; i++) wr(3'd0, 8'(i));
    irq_chk("R7 below threshold 4", 1'b0);
    wr(3'd0, 8'h03);
    irq_chk("R7 threshold 4 reached", 1'b1);
    rd_chk("R12 rx id again", 3'd2, 8'hC4);

    // R7: single-entry mode forces threshold 1
    wr(3'd2, 8'hC2);
    wr(3'd0, 8'h77);
    irq_chk("R7 forced threshold 1", 1'b1);
    rd_chk("R12 id shallow queue", 3'd2, 8'h04);
    rd_chk("R3 pop forced", 3'd0, 8'h77);

    // R9: empty-on-enable interrupt
    wr(3'd1, 8'h02);
    irq_chk("R9 enable while empty", 1'b1);
    rd_chk("R12 thre id", 3'd2, 8'h02);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h31);
    wr(3'd1, 8'h02);
    irq_chk("R9 enable while not empty", 1'b0);
    rd_chk("R3 pop", 3'd0, 8'h31);

    // R10: modem-control write interrupt
    wr(3'd1, 8'h08);
    wr(3'd4, 8'h01);
    irq_chk("R10 bit0", 1'b1);
    rd_chk("R12 modem id", 3'd2, 8'h00);
    wr(3'd4, 8'h04);
    irq_chk("R10 other bit silent", 1'b0);
    wr(3'd4, 8'h08);
    irq_chk("R10 bit3", 1'b1);
    rd_chk("R12 modem id again", 3'd2, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h0B);
    irq_chk("R10 disabled", 1'b0);
    rd_chk("R10 readback", 3'd4, 8'h0B);

    // R12: overrun outranks threshold, one read clears both
    wr(3'd1, 8'h05);
    wr(3'd0, 8'hAA);
    wr(3'd0, 8'hBB);
    rd_chk("R12 priority", 3'd2, 8'h06);
    irq_chk("R12 all cleared", 1'b0);
    rd_chk("R5 flag", 3'd5, 8'h63);
    rd_chk("R3 kept byte", 3'd0, 8'hAA);
    wr(3'd1, 8'h00);

    // R13: push and pop together on a full single-entry queue
    wr(3'd0, 8'h5C);
    acc(1'b1, 1'b1, 3'd0, 8'h99, q);
    chk("R13 returns old head", q, 8'h5C);
    rd_chk("R13 one entry no overrun", 3'd5, 8'h61);
    rd_chk("R13 new byte stored", 3'd0, 8'h99);

    // R1: reset in mid-run
    wr(3'd7, 8'h3C);
    wr(3'd3, 8'h9F);
    do_reset();
    rd_chk("R1 status", 3'd5, 8'h60);
    rd_chk("R1 line ctl", 3'd3, 8'h00);
    rd_chk("R1 scratch", 3'd7, 8'h00);
    rd_chk("R1 modem ctl", 3'd4, 8'h00);
    irq_chk("R1 irq", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule